// File: doc/BRIEF.md
# Bus Master Activity Break Detector

This block sits next to the processor idle-state sequencer and watches every agent that can take over the memory bus. It looks at the external PCI request lines, the internal master requests, a graphics-port busy line, the run state of two USB host controllers, the start bit of the IDE bus-master engine and the interrupt-request lines. Any of these counts as a break event. On a break event the block sets a sticky status flag that software clears by writing 1. While the deepest idle state (C3) is in force, the first break event also produces a single-cycle break request to the sequencer.

The active-low lines from outside the clock domain are the PCI requests, graphics busy and interrupt requests. Each passes through a two-flop synchronizer before it is used. The internal requests, USB state, IDE start bit and idle input are taken as synchronous to the clock.

The break request comes from a four-state machine:
- **RUN**: not idle.
- **ARMED**: idle, no event seen yet.
- **BREAK**: the pulse cycle.
- **HELD**: idle, pulse already given.

Its transitions are:
- RUN→BREAK when idle and an event are present together.
- RUN→ARMED when idle is present without an event.
- ARMED→RUN when idle drops. This takes priority over an event.
- ARMED→BREAK on an event.
- BREAK→HELD while idle stays high.
- BREAK→RUN when idle drops.
- HELD→RUN when idle drops.

Top module: `bm_break_det`

## Requirements
- R1: While `rst_n` is low, `bm_sts` and `break_req` are 0.
- R2: `pci_req_n`, `gfx_busy_n` and `irq_n` are active-low and are used only after a two-flop synchronizer. A low driven before clock edge k sets `bm_sts` at edge k+2. A synchronous source driven before edge k sets it at edge k.
- R3: Any of the following sets `bm_sts` on the next edge:
  - any `pci_req_n` bit at 0,
  - any `int_req` bit at 1,
  - `gfx_busy_n` at 0.
- R4: USB controller c counts as active only when all three hold: `usb_gsusp[c]` is 0, at least one bit of `usb_port_susp[c*P +: P]` is 0, and `usb_run[c]` is 1. If any one condition fails, that controller sets nothing.
- R5: `ide_start` at 1 counts as activity on its own.
- R6: Any `irq_n` bit at 0 is a break event. It sets `bm_sts` and can cause a break request.
- R7: `bm_sts` stays 1 after all events are gone. Only a cycle with `sts_wr`=1 and `sts_wdata`=1 clears it. A write with `sts_wdata`=0 has no effect.
- R8: If a break event and a clearing write occur in the same cycle, `bm_sts` is 1 afterwards.
- R9: `break_req` is high for exactly one cycle. It is registered, and rises at the edge that samples the first break event while `idle_c3` is 1.
- R10: After a break pulse, no further pulse occurs until `idle_c3` has been 0 and then 1 again. No pulse occurs while `idle_c3` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pci_req_n | input | N_PCI | PCI request lines, active low, asynchronous |
| int_req | input | N_INT | Internal master requests, active high |
| gfx_busy_n | input | 1 | Graphics port busy, active low, asynchronous |
| irq_n | input | N_IRQ | Interrupt request lines, active low, asynchronous |
| usb_gsusp | input | 2 | Per-controller global suspend |
| usb_run | input | 2 | Per-controller run bit |
| usb_port_susp | input | 2*N_PORTS | Port suspend flags, controller c at [c*N_PORTS +: N_PORTS] |
| ide_start | input | 1 | IDE bus-master start bit |
| idle_c3 | input | 1 | Processor is in the C3 idle state |
| sts_wr | input | 1 | Write strobe for the status bit |
| sts_wdata | input | 1 | Write data; 1 clears the status |
| bm_sts | output | 1 | Sticky bus-master status |
| break_req | output | 1 | One-cycle break request |

## Verification
The assertions assume the following inputs are already synchronous to `clk`:
- the internal requests,
- the USB state,
- the IDE start bit,
- `idle_c3`,
- the status write pair.

They also assume that any event seen by the state machine has come through the synchronizers, so it is settled. The stimulus respects this by changing every input only at the falling edge. Random phases keep each source's activity rare enough that the sticky flag is regularly cleared and re-set, and that idle entry and exit are interleaved with events.

// File: rtl/bm_break_pkg.sv
package bm_break_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_ARMED = 2'd1,
        ST_BREAK = 2'd2,
        ST_HELD  = 2'd3
    } brk_state_e;

    localparam int N_USB_CTRL = 2;
endpackage

// File: rtl/bm_sync.sv
module bm_sync #(
    parameter int         W       = 1,
    parameter logic       RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= {W{RST_VAL}};
            q_sync <= {W{RST_VAL}};
        end else begin
            stage1 <= d_async;
            q_sync <= stage1;
        end
    end
endmodule

// File: rtl/bm_activity.sv
module bm_activity
    import bm_break_pkg::*;
#(
    parameter int N_PCI   = 6,
    parameter int N_INT   = 4,
    parameter int N_IRQ   = 4,
    parameter int N_PORTS = 2
) (
    input  logic                          pci_s_n,
    input  logic [N_INT-1:0]              int_req,
    input  logic                          gfx_s_n,
    input  logic                          irq_s_n,
    input  logic [N_USB_CTRL-1:0]         usb_gsusp,
    input  logic [N_USB_CTRL-1:0]         usb_run,
    input  logic [N_USB_CTRL*N_PORTS-1:0] usb_port_susp,
    input  logic                          ide_start,
    output logic                          event_any
);
    logic [N_USB_CTRL-1:0] usb_act;

    for (genvar c = 0; c < N_USB_CTRL; c++) begin : g_usb
        logic some_port_awake;
        assign some_port_awake = ~&usb_port_susp[c*N_PORTS +: N_PORTS];
        assign usb_act[c]      = !usb_gsusp[c] && some_port_awake && usb_run[c];
    end

    always_comb begin
        event_any = !pci_s_n || (|int_req) || !gfx_s_n || !irq_s_n
                    || (|usb_act) || ide_start;
    end
endmodule

// File: rtl/bm_sts_reg.sv
module bm_sts_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_set,
    input  logic sw_wr,
    input  logic sw_data,
    output logic sts
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              sts <= 1'b0;
        else if (hw_set)         sts <= 1'b1;
        else if (sw_wr && sw_data) sts <= 1'b0;
    end
endmodule

// File: rtl/bm_break_fsm.sv
module bm_break_fsm
    import bm_break_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic idle_c3,
    input  logic event_any,
    output logic break_req
);
    brk_state_e state, state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_RUN: begin
                if (idle_c3) state_nxt = event_any ? ST_BREAK : ST_ARMED;
            end
            ST_ARMED: begin
                if (!idle_c3)       state_nxt = ST_RUN;
                else if (event_any) state_nxt = ST_BREAK;
            end
            ST_BREAK: begin
                state_nxt = idle_c3 ? ST_HELD : ST_RUN;
            end
            ST_HELD: begin
                if (!idle_c3) state_nxt = ST_RUN;
            end
            default: state_nxt = ST_RUN;
        endcase
    end

    always_comb begin
        break_req = (state == ST_BREAK);
    end
endmodule

// File: rtl/bm_break_det.sv
module bm_break_det
    import bm_break_pkg::*;
#(
    parameter int N_PCI   = 6,
    parameter int N_INT   = 4,
    parameter int N_IRQ   = 4,
    parameter int N_PORTS = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_PCI-1:0]              pci_req_n,
    input  logic [N_INT-1:0]              int_req,
    input  logic                          gfx_busy_n,
    input  logic [N_IRQ-1:0]              irq_n,
    input  logic [N_USB_CTRL-1:0]         usb_gsusp,
    input  logic [N_USB_CTRL-1:0]         usb_run,
    input  logic [N_USB_CTRL*N_PORTS-1:0] usb_port_susp,
    input  logic                          ide_start,
    input  logic                          idle_c3,
    input  logic                          sts_wr,
    input  logic                          sts_wdata,
    output logic                          bm_sts,
    output logic                          break_req
);
    localparam int N_ASYNC = N_PCI + 1 + N_IRQ;

    logic [N_ASYNC-1:0] async_raw, async_s;
    logic               pci_s_n, gfx_s_n, irq_s_n;
    logic               event_any;

    assign async_raw = {irq_n, gfx_busy_n, pci_req_n};

    bm_sync #(.W(N_ASYNC), .RST_VAL(1'b1)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async(async_raw),
        .q_sync (async_s)
    );

    assign pci_s_n = &async_s[N_PCI-1:0];
    assign gfx_s_n = async_s[N_PCI];
    assign irq_s_n = &async_s[N_ASYNC-1:N_PCI+1];

    bm_activity #(
        .N_PCI(N_PCI), .N_INT(N_INT), .N_IRQ(N_IRQ), .N_PORTS(N_PORTS)
    ) u_act (
        .pci_s_n      (pci_s_n),
        .int_req      (int_req),
        .gfx_s_n      (gfx_s_n),
        .irq_s_n      (irq_s_n),
        .usb_gsusp    (usb_gsusp),
        .usb_run      (usb_run),
        .usb_port_susp(usb_port_susp),
        .ide_start    (ide_start),
        .event_any    (event_any)
    );

    bm_sts_reg u_sts (
        .clk    (clk),
        .rst_n  (rst_n),
        .hw_set (event_any),
        .sw_wr  (sts_wr),
        .sw_data(sts_wdata),
        .sts    (bm_sts)
    );

    bm_break_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .idle_c3  (idle_c3),
        .event_any(event_any),
        .break_req(break_req)
    );
endmodule

// File: rtl/bm_break_chk.sv
module bm_break_chk (
    input logic clk,
    input logic rst_n,
    input logic idle_c3,
    input logic sts_wr,
    input logic sts_wdata,
    input logic event_any,
    input logic bm_sts,
    input logic break_req
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!bm_sts && !break_req));

    // R7
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bm_sts && !(sts_wr && sts_wdata)) |=> bm_sts);

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        event_any |=> bm_sts);

    // R7
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bm_sts && !event_any) |=> !bm_sts);

    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        break_req |=> !break_req);

    // R10
    pulse_in_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(break_req) |-> ($past(idle_c3) && $past(event_any)));
endmodule

bind bm_break_det bm_break_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .idle_c3  (idle_c3),
    .sts_wr   (sts_wr),
    .sts_wdata(sts_wdata),
    .event_any(event_any),
    .bm_sts   (bm_sts),
    .break_req(break_req)
);

// File: tb/bm_break_det_bench.sv
`timescale 1ns/1ps
module bm_break_det_bench;
    localparam int N_PCI = 6, N_INT = 4, N_IRQ = 4, N_PORTS = 2, NC = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N_PCI-1:0]      pci_req_n = '1;
    logic [N_INT-1:0]      int_req = '0;
    logic                  gfx_busy_n = 1'b1;
    logic [N_IRQ-1:0]      irq_n = '1;
    logic [NC-1:0]         usb_gsusp = '1;
    logic [NC-1:0]         usb_run = '0;
    logic [NC*N_PORTS-1:0] usb_port_susp = '1;
    logic                  ide_start = 1'b0;
    logic                  idle_c3 = 1'b0;
    logic                  sts_wr = 1'b0;
    logic                  sts_wdata = 1'b0;
    logic                  bm_sts, break_req;

    int checks = 0, failures = 0;
    bit started = 0;
    string tag = "R1";

    always #2.5 clk = ~clk;

    bm_break_det u_bm_break_det (.*);

    // reference state from the requirements
    logic [N_PCI-1:0] m_pci1 = '1, m_pci2 = '1;
    logic [N_IRQ-1:0] m_irq1 = '1, m_irq2 = '1;
    logic m_gfx1 = 1, m_gfx2 = 1;
    logic m_sts = 0, m_brk = 0, m_fired = 0;

    function automatic logic usb_on(logic gs, logic [N_PORTS-1:0] ps, logic run);
        return !gs && !(&ps) && run;
    endfunction

    function automatic logic any_event();
        logic u = 1'b0;
        for (int c = 0; c < NC; c++)
            u |= usb_on(usb_gsusp[c], usb_port_susp[c*N_PORTS +: N_PORTS], usb_run[c]);
        return !(&m_pci2) || (|int_req) || !m_gfx2 || !(&m_irq2) || u || ide_start;
    endfunction

    always @(posedge clk) begin
        started <= 1;
        if (!rst_n) begin
            m_pci1 = '1; m_pci2 = '1; m_irq1 = '1; m_irq2 = '1;
            m_gfx1 = 1; m_gfx2 = 1; m_sts = 0; m_brk = 0; m_fired = 0;
        end else begin
            logic ev;
            ev = any_event();
            m_sts   = ev ? 1'b1 : ((sts_wr && sts_wdata) ? 1'b0 : m_sts);
            m_brk   = idle_c3 && ev && !m_fired;
            m_fired = idle_c3 && (m_fired || ev);
            m_pci2 = m_pci1; m_pci1 = pci_req_n;
            m_irq2 = m_irq1; m_irq1 = irq_n;
            m_gfx2 = m_gfx1; m_gfx1 = gfx_busy_n;
        end
    end

    task automatic chk(string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            chk("bm_sts", bm_sts, m_sts);
            chk("break_req", break_req, m_brk);
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic quiet();
        pci_req_n = '1; int_req = '0; gfx_busy_n = 1; irq_n = '1;
        usb_gsusp = '1; usb_run = '0; usb_port_susp = '1; ide_start = 0;
        sts_wr = 0; sts_wdata = 0;
    endtask

    task automatic clear_sts();
        sts_wr = 1; sts_wdata = 1; step(1); sts_wr = 0; sts_wdata = 0; step(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h00C3_B0B5));
        tag = "R1"; step(4); rst_n = 1; step(2);

        tag = "R2"; pci_req_n[2] = 0; step(4); quiet(); step(3); clear_sts();
        tag = "R2"; gfx_busy_n = 0; step(1); gfx_busy_n = 1; step(4); clear_sts();
        tag = "R3"; int_req[1] = 1; step(2); quiet(); step(1); clear_sts();

        tag = "R4"; usb_gsusp[0] = 1; usb_run[0] = 1; usb_port_susp[0] = 0; step(3);
        usb_gsusp[0] = 0; usb_port_susp[1:0] = 2'b11; step(3);
        usb_port_susp[1:0] = 2'b10; usb_run[0] = 0; step(3);
        usb_run[0] = 1; step(2); quiet(); step(1); clear_sts();
        usb_gsusp[1] = 0; usb_run[1] = 1; usb_port_susp[3:2] = 2'b01; step(2); quiet(); clear_sts();

        tag = "R5"; ide_start = 1; step(2); quiet(); clear_sts();
        tag = "R6"; irq_n[3] = 0; step(4); irq_n = '1; step(3); clear_sts();

        tag = "R7"; ide_start = 1; step(1); quiet(); step(5);
        sts_wr = 1; sts_wdata = 0; step(1); sts_wr = 0; step(2); clear_sts(); step(2);

        tag = "R8"; ide_start = 1; sts_wr = 1; sts_wdata = 1; step(1); quiet(); step(2); clear_sts();

        tag = "R9"; idle_c3 = 1; step(3); ide_start = 1; step(1); ide_start = 0; step(4);
        tag = "R10"; int_req[0] = 1; step(2); int_req = '0; step(2);
        idle_c3 = 0; ide_start = 1; step(3);
        idle_c3 = 1; step(3); ide_start = 0; idle_c3 = 0; step(2); clear_sts();

        tag = "R3";
        for (int i = 0; i < 4000; i++) begin
            quiet();
            if ($urandom % 20 == 0) pci_req_n[$urandom % N_PCI] = 0;
            if ($urandom % 24 == 0) int_req[$urandom % N_INT] = 1;
            if ($urandom % 30 == 0) gfx_busy_n = 0;
            if ($urandom % 30 == 0) irq_n[$urandom % N_IRQ] = 0;
            for (int c = 0; c < NC; c++) begin
                usb_gsusp[c] = ($urandom % 10) != 0;
                usb_run[c]   = $urandom % 2;
                usb_port_susp[c*N_PORTS +: N_PORTS] = N_PORTS'($urandom);
            end
            ide_start = ($urandom % 40) == 0;
            if ($urandom % 16 == 0) idle_c3 = !idle_c3;
            if ($urandom % 4 == 0) begin sts_wr = 1; sts_wdata = $urandom % 2; end
            step(1);
        end
        quiet(); idle_c3 = 0; step(4);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule